// File: doc/BRIEF.md
# Radio State Sequencer

The sequencer moves a low-power transceiver between its operating states in response to one-byte command strobes from the host interface. Supported states are sleep, idle, measure, PHY-ready, receive and transmit. Each accepted move holds a busy interval that models analog settling. The current state is shown as a 4-bit code, and the ready flag is low for the whole interval. A host waits for the ready flag before it sends the next strobe.

The block has two special strobes. One asks for a channel-clear check and is allowed only in receive. The other hands the channel-access transmit sequence to an external engine. For that sequence the block emits a one-cycle start pulse, stays busy until the engine reports completion, and then settles in PHY-ready. A packet event in receive or transmit also drops the block to PHY-ready, where it stays until a new command arrives. Two reset strobes are provided. The full reset returns the block to sleep and clears its error record. The lighter one only cancels the sequence in progress and leaves the state unchanged.

Top module: `radio_state_seq`

## Requirements
- R1: After reset, state_o is 0 (sleep), rdy_o is 1, and cmd_err_o, csma_start_o and cca_clear_o are 0.
- R2: Opcode 0xB2 selects idle (code 1), 0xB6 measure (code 2), 0xB3 PHY-ready (code 3), 0xB4 receive (code 4), 0xB5 transmit (code 5) and 0xB1 sleep (code 0).
- R3: An accepted state command holds rdy_o low for exactly SETTLE_CYC cycles after the accepting edge. state_o keeps the old code during that time and takes the new code at the edge where rdy_o rises.
- R4: In sleep, only 0xB2 is accepted, and its busy time is WAKE_CYC cycles. Any other state, check or access command in sleep is ignored and sets cmd_err_o.
- R5: A command that arrives while rdy_o is low, including in the cycle of the completing edge, is ignored and sets cmd_err_o. cmd_err_o stays set until opcode 0xC8.
- R6: With STRICT_DECODE=1, an opcode outside the map is ignored and sets cmd_err_o.
- R7: A pkt_evt_i pulse in receive or transmit, while ready, moves state_o to PHY-ready at the next edge, and the block stays there. The pulse has no effect in other states. A command accepted in the same cycle takes precedence.
- R8: Opcode 0xC1, in any state other than sleep, raises csma_start_o for exactly the one cycle after acceptance. rdy_o then stays low until csma_done_i is sampled, and at that edge state_o becomes PHY-ready.
- R9: Opcode 0xB7 in receive holds rdy_o low for CCA_CYC cycles and leaves state_o at receive. cca_clear_o is loaded with the inverse of chan_busy_i at the completing edge. Outside receive, 0xB7 is ignored and sets cmd_err_o.
- R10: Opcode 0xC8 is taken at any time, even while busy. At the next edge it gives state_o 0, rdy_o 1, cmd_err_o 0 and cca_clear_o 0, and the pending move is cancelled.
- R11: Opcode 0xC7 is taken at any time. It cancels a pending move or access wait, and at the next edge rdy_o is 1 while state_o and cmd_err_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command opcode |
| pkt_evt_i | input | 1 | Packet received or sent event |
| chan_busy_i | input | 1 | Channel energy above threshold |
| csma_done_i | input | 1 | Channel-access engine finished |
| rdy_o | output | 1 | High when no transition is in progress |
| state_o | output | 4 | Current state code |
| cmd_err_o | output | 1 | Sticky rejected-command flag |
| csma_start_o | output | 1 | One-cycle start to the channel-access engine |
| cca_clear_o | output | 1 | Result of the last channel check |

## Verification
Two functions can meet in one cycle, and both collisions are provoked on purpose. In the first, a packet event and a measure command strobe are driven together while in receive. The bench expects the command to win: state_o must still read receive during the busy interval and end at measure, never at PHY-ready. In the second, a receive command is timed to land exactly on the edge that completes a PHY-ready move. The bench expects that strobe to be rejected, so the state ends at PHY-ready with cmd_err_o set.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [3:0] {
      ST_SLEEP  = 4'd0,
      ST_IDLE   = 4'd1,
      ST_MEAS   = 4'd2,
      ST_PHYRDY = 4'd3,
      ST_RX     = 4'd4,
      ST_TX     = 4'd5
   } rc_state_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_GOTO,
      K_CCA,
      K_CSMA,
      K_PCRST,
      K_FULLRST,
      K_BAD
   } op_kind_e;

   typedef struct packed {
      op_kind_e  kind;
      rc_state_e dest;
   } op_dec_t;

   localparam logic [7:0] OPC_SLEEP   = 8'hB1;
   localparam logic [7:0] OPC_IDLE    = 8'hB2;
   localparam logic [7:0] OPC_PHYRDY  = 8'hB3;
   localparam logic [7:0] OPC_RX      = 8'hB4;
   localparam logic [7:0] OPC_TX      = 8'hB5;
   localparam logic [7:0] OPC_MEAS    = 8'hB6;
   localparam logic [7:0] OPC_CCA     = 8'hB7;
   localparam logic [7:0] OPC_CSMA    = 8'hC1;
   localparam logic [7:0] OPC_PCRST   = 8'hC7;
   localparam logic [7:0] OPC_FULLRST = 8'hC8;

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
   import rsq_pkg::*;
#(
   parameter int OPC_W         = 8,
   parameter bit STRICT_DECODE = 1'b1
) (
   input  logic             valid_i,
   input  logic [OPC_W-1:0] code_i,
   output op_dec_t          dec_o
);

   op_dec_t raw;
   logic    unknown;

   always_comb begin
      raw.kind = K_NONE;
      raw.dest = ST_SLEEP;
      unknown  = 1'b0;
      if (valid_i) begin
         case (code_i)
            OPC_SLEEP:   begin raw.kind = K_GOTO; raw.dest = ST_SLEEP;  end
            OPC_IDLE:    begin raw.kind = K_GOTO; raw.dest = ST_IDLE;   end
            OPC_PHYRDY:  begin raw.kind = K_GOTO; raw.dest = ST_PHYRDY; end
            OPC_RX:      begin raw.kind = K_GOTO; raw.dest = ST_RX;     end
            OPC_TX:      begin raw.kind = K_GOTO; raw.dest = ST_TX;     end
            OPC_MEAS:    begin raw.kind = K_GOTO; raw.dest = ST_MEAS;   end
            OPC_CCA:     raw.kind = K_CCA;
            OPC_CSMA:    raw.kind = K_CSMA;
            OPC_PCRST:   raw.kind = K_PCRST;
            OPC_FULLRST: raw.kind = K_FULLRST;
            default:     unknown  = 1'b1;
         endcase
      end
   end

   generate
      if (STRICT_DECODE) begin : g_strict
         always_comb begin
            dec_o = raw;
            if (unknown) dec_o.kind = K_BAD;
         end
      end else begin : g_lenient
         always_comb begin
            dec_o = raw;
            if (unknown) dec_o.kind = K_NONE;
         end
      end
   endgenerate

   always_comb begin
      if (!valid_i) assert (dec_o.kind == K_NONE)
         else $error("p_idle_decode_r6: decode active without strobe");
   end

endmodule

// File: rtl/rsq_guard.sv
module rsq_guard
   import rsq_pkg::*;
(
   input  op_dec_t   dec_i,
   input  rc_state_e state_i,
   input  logic      busy_i,
   output logic      accept_o,
   output logic      reject_o
);

   logic legal;
   logic needs_idle;

   always_comb begin
      legal = 1'b0;
      case (dec_i.kind)
         K_GOTO: legal = (state_i == ST_SLEEP) ? (dec_i.dest == ST_IDLE) : 1'b1;
         K_CCA:  legal = (state_i == ST_RX);
         K_CSMA: legal = (state_i != ST_SLEEP);
         default: legal = 1'b0;
      endcase
   end

   assign needs_idle = (dec_i.kind == K_GOTO) || (dec_i.kind == K_CCA) ||
                       (dec_i.kind == K_CSMA);

   assign accept_o = needs_idle && legal && !busy_i;
   assign reject_o = (needs_idle && !(legal && !busy_i)) || (dec_i.kind == K_BAD);

   always_comb begin
      assert (!(accept_o && reject_o))
         else $error("p_accept_xor_reject_r5: both accept and reject");
   end

endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          abort_i,
   output logic          busy_o,
   output logic          done_o
);

   logic [CW-1:0] cnt;

   assign done_o = busy_o && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
      end else if (abort_i) begin
         busy_o <= 1'b0;
         cnt    <= '0;
      end else if (load_i) begin
         busy_o <= 1'b1;
         cnt    <= load_val_i;
      end else if (done_o) begin
         busy_o <= 1'b0;
      end else if (busy_o) begin
         cnt <= cnt - 1'b1;
      end
   end

   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt != '0 && !load_i && !abort_i) |=> (busy_o && cnt == $past(cnt) - 1'b1))
      else $error("p_count_down_r3");

   p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !load_i) |=> !busy_o)
      else $error("p_done_ends_r3");

endmodule

// File: rtl/radio_state_seq.sv
module radio_state_seq
   import rsq_pkg::*;
#(
   parameter int SETTLE_CYC    = 4,
   parameter int WAKE_CYC      = 12,
   parameter int CCA_CYC       = 6,
   parameter bit STRICT_DECODE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid_i,
   input  logic [7:0] cmd_code_i,
   input  logic       pkt_evt_i,
   input  logic       chan_busy_i,
   input  logic       csma_done_i,
   output logic       rdy_o,
   output logic [3:0] state_o,
   output logic       cmd_err_o,
   output logic       csma_start_o,
   output logic       cca_clear_o
);

   localparam int MAX_A = (SETTLE_CYC > WAKE_CYC) ? SETTLE_CYC : WAKE_CYC;
   localparam int MAX_D = (MAX_A > CCA_CYC) ? MAX_A : CCA_CYC;
   localparam int CW    = (MAX_D < 2) ? 1 : $clog2(MAX_D);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("WAKE_CYC must be at least 1");
      end
      if (CCA_CYC < 1) begin : g_bad_cca
         $error("CCA_CYC must be at least 1");
      end
   endgenerate

   op_dec_t       dec;
   rc_state_e     state_q;
   rc_state_e     pend_dest;
   logic          pend_cca;
   logic          csma_wait;
   logic          tmr_busy;
   logic          tmr_done;
   logic          busy;
   logic          accept;
   logic          reject;
   logic          full_rst;
   logic          pc_rst;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;

   rsq_decode #(
      .OPC_W         (8),
      .STRICT_DECODE (STRICT_DECODE)
   ) u_decode (
      .valid_i (cmd_valid_i),
      .code_i  (cmd_code_i),
      .dec_o   (dec)
   );

   rsq_guard u_guard (
      .dec_i    (dec),
      .state_i  (state_q),
      .busy_i   (busy),
      .accept_o (accept),
      .reject_o (reject)
   );

   assign full_rst = (dec.kind == K_FULLRST);
   assign pc_rst   = (dec.kind == K_PCRST);
   assign tmr_load = accept && (dec.kind != K_CSMA);

   always_comb begin
      if (dec.kind == K_CCA)
         tmr_val = CW'(CCA_CYC - 1);
      else if (state_q == ST_SLEEP)
         tmr_val = CW'(WAKE_CYC - 1);
      else
         tmr_val = CW'(SETTLE_CYC - 1);
   end

   rsq_timer #(
      .CW (CW)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .abort_i    (full_rst || pc_rst),
      .busy_o     (tmr_busy),
      .done_o     (tmr_done)
   );

   assign busy = tmr_busy || csma_wait;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_SLEEP;
         pend_dest    <= ST_SLEEP;
         pend_cca     <= 1'b0;
         csma_wait    <= 1'b0;
         csma_start_o <= 1'b0;
         cmd_err_o    <= 1'b0;
         cca_clear_o  <= 1'b0;
      end else begin
         csma_start_o <= 1'b0;
         if (full_rst) begin
            state_q     <= ST_SLEEP;
            pend_cca    <= 1'b0;
            csma_wait   <= 1'b0;
            cmd_err_o   <= 1'b0;
            cca_clear_o <= 1'b0;
         end else if (pc_rst) begin
            pend_cca  <= 1'b0;
            csma_wait <= 1'b0;
         end else begin
            if (reject) cmd_err_o <= 1'b1;
            if (accept) begin
               case (dec.kind)
                  K_GOTO: begin
                     pend_dest <= dec.dest;
                     pend_cca  <= 1'b0;
                  end
                  K_CCA:  pend_cca <= 1'b1;
                  K_CSMA: begin
                     csma_wait    <= 1'b1;
                     csma_start_o <= 1'b1;
                  end
                  default: pend_cca <= pend_cca;
               endcase
            end else if (tmr_done) begin
               if (pend_cca) cca_clear_o <= ~chan_busy_i;
               else          state_q     <= pend_dest;
               pend_cca <= 1'b0;
            end else if (csma_wait && csma_done_i) begin
               csma_wait <= 1'b0;
               state_q   <= ST_PHYRDY;
            end else if (!busy && pkt_evt_i &&
                         (state_q == ST_RX || state_q == ST_TX)) begin
               state_q <= ST_PHYRDY;
            end
         end
      end
   end

   assign rdy_o   = ~busy;
   assign state_o = state_q;

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (state_o == 4'd0 || !rst_n))
      else $error("p_reset_state_r1");

   p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && rdy_o && state_o == 4'd4 && cmd_code_i == 8'hB3) |=> !rdy_o)
      else $error("p_ready_drops_r3");

   p_state_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_o && !(cmd_valid_i && cmd_code_i == 8'hC8)) |=> (rdy_o || $stable(state_o)))
      else $error("p_state_hold_busy_r3");

   p_sleep_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd0) |=> (state_o == 4'd0 || state_o == 4'd1))
      else $error("p_sleep_exit_r4");

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_err_o && !(cmd_valid_i && cmd_code_i == 8'hC8)) |=> cmd_err_o)
      else $error("p_err_sticky_r5");

   p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      csma_start_o |=> !csma_start_o)
      else $error("p_start_pulse_r8");

   p_full_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_code_i == 8'hC8) |=> (state_o == 4'd0 && rdy_o && !cmd_err_o))
      else $error("p_full_reset_r10");

   p_pc_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_code_i == 8'hC7) |=> (rdy_o && $stable(state_o) && $stable(cmd_err_o)))
      else $error("p_pc_reset_r11");

endmodule

// File: tb/radio_state_seq_tb.sv
module radio_state_seq_tb;

   localparam int SETTLE = 4;
   localparam int WAKE   = 12;
   localparam int CCA    = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'h00;
   logic       pkt_evt = 1'b0;
   logic       chan_busy = 1'b0;
   logic       csma_done = 1'b0;
   logic       rdy;
   logic [3:0] state;
   logic       err;
   logic       csma_start;
   logic       cca_clear;

   int checks = 0;
   int fails  = 0;

   always #5ns clk = ~clk;

   radio_state_seq #(
      .SETTLE_CYC    (SETTLE),
      .WAKE_CYC      (WAKE),
      .CCA_CYC       (CCA),
      .STRICT_DECODE (1'b1)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid_i  (cmd_valid),
      .cmd_code_i   (cmd_code),
      .pkt_evt_i    (pkt_evt),
      .chan_busy_i  (chan_busy),
      .csma_done_i  (csma_done),
      .rdy_o        (rdy),
      .state_o      (state),
      .cmd_err_o    (err),
      .csma_start_o (csma_start),
      .cca_clear_o  (cca_clear)
   );

   // code, expected state, expected error, expected busy cycles, tag
   localparam int NVEC = 12;
   localparam logic [23:0] VEC [NVEC] = '{
      {8'hB2, 4'd1, 1'b0, 7'd12, 4'd4},
      {8'hB3, 4'd3, 1'b0, 7'd4,  4'd2},
      {8'hB4, 4'd4, 1'b0, 7'd4,  4'd2},
      {8'hB6, 4'd2, 1'b0, 7'd4,  4'd2},
      {8'hB5, 4'd5, 1'b0, 7'd4,  4'd3},
      {8'hB1, 4'd0, 1'b0, 7'd4,  4'd2},
      {8'hB4, 4'd0, 1'b1, 7'd0,  4'd4},
      {8'hC8, 4'd0, 1'b0, 7'd0,  4'd10},
      {8'hB2, 4'd1, 1'b0, 7'd12, 4'd4},
      {8'h55, 4'd1, 1'b1, 7'd0,  4'd6},
      {8'hC7, 4'd1, 1'b1, 7'd0,  4'd11},
      {8'hC8, 4'd0, 1'b0, 7'd0,  4'd10}
   };

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd2:  return "R2";
         4'd3:  return "R3";
         4'd4:  return "R4";
         4'd6:  return "R6";
         4'd10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] c);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (!rdy && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic go(input logic [7:0] c);
      int n;
      issue(c);
      busy_len(n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 state", state, 0);
      check("R1 rdy", rdy, 1);
      check("R1 err", err, 0);
      check("R1 csma_start", csma_start, 0);
      check("R1 cca_clear", cca_clear, 0);

      for (int i = 0; i < NVEC; i++) begin
         issue(VEC[i][23:16]);
         busy_len(n);
         check({tag_name(VEC[i][3:0]), " busy cycles"}, n, int'(VEC[i][10:4]));
         check({tag_name(VEC[i][3:0]), " state"}, state, int'(VEC[i][15:12]));
         check({tag_name(VEC[i][3:0]), " err"}, err, int'(VEC[i][11]));
      end

      // R3: old code held while busy, new code when ready rises
      go(8'hB2);
      issue(8'hB3);
      check("R3 old state while busy", state, 1);
      check("R3 ready low", rdy, 0);
      busy_len(n);
      check("R3 new state", state, 3);

      // R5: command while busy is ignored
      issue(8'hB4);
      issue(8'hB6);
      busy_len(n);
      check("R5 busy cmd ignored state", state, 4);
      check("R5 err set", err, 1);
      @(negedge clk);
      check("R5 err sticky", err, 1);
      go(8'hC8);

      // R5: command on the completing edge is rejected
      go(8'hB2);
      issue(8'hB3);
      repeat (SETTLE - 1) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = 8'hB4;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R5 edge collision state", state, 3);
      check("R5 edge collision rdy", rdy, 1);
      check("R5 edge collision err", err, 1);
      go(8'hC8);

      // R10: full reset while busy
      issue(8'hB2);
      issue(8'hC8);
      check("R10 state", state, 0);
      check("R10 rdy", rdy, 1);
      repeat (WAKE + 2) @(negedge clk);
      check("R10 pending cancelled", state, 0);

      // R11: pc reset while busy keeps state and error
      go(8'h55);
      issue(8'hB2);
      issue(8'hC7);
      check("R11 rdy", rdy, 1);
      check("R11 state", state, 0);
      check("R11 err kept", err, 1);
      repeat (WAKE + 2) @(negedge clk);
      check("R11 pending cancelled", state, 0);
      go(8'hC8);

      // R7: packet event in receive
      go(8'hB2);
      go(8'hB4);
      pkt_evt = 1'b1;
      @(negedge clk);
      pkt_evt = 1'b0;
      check("R7 to phy-ready", state, 3);
      repeat (5) @(negedge clk);
      check("R7 stays phy-ready", state, 3);
      // R7: ignored in idle
      go(8'hB2);
      pkt_evt = 1'b1;
      @(negedge clk);
      pkt_evt = 1'b0;
      check("R7 ignored in idle", state, 1);
      // R7: command wins over same-cycle packet event
      go(8'hB4);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = 8'hB6;
      pkt_evt   = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      pkt_evt   = 1'b0;
      check("R7 collision state during busy", state, 4);
      busy_len(n);
      check("R7 collision busy", n, SETTLE);
      check("R7 collision final", state, 2);

      // R8: channel-access sequence from receive
      go(8'hB4);
      issue(8'hC1);
      check("R8 start pulse", csma_start, 1);
      @(negedge clk);
      check("R8 start one cycle", csma_start, 0);
      check("R8 busy", rdy, 0);
      repeat (3) @(negedge clk);
      check("R8 still busy", rdy, 0);
      csma_done = 1'b1;
      @(negedge clk);
      csma_done = 1'b0;
      check("R8 state phy-ready", state, 3);
      check("R8 ready", rdy, 1);

      // R9: channel check in receive
      go(8'hB4);
      chan_busy = 1'b0;
      issue(8'hB7);
      busy_len(n);
      check("R9 cca busy", n, CCA);
      check("R9 state rx", state, 4);
      check("R9 clear", cca_clear, 1);
      chan_busy = 1'b1;
      issue(8'hB7);
      busy_len(n);
      check("R9 not clear", cca_clear, 0);
      chan_busy = 1'b0;
      go(8'hB2);
      issue(8'hB7);
      check("R9 rejected outside rx rdy", rdy, 1);
      check("R9 rejected err", err, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule